// File: doc/BRIEF.md
# Elastic-Buffer Mesh Router Core

A five-port packet-switched router for a two-dimensional mesh that keeps no virtual-channel storage. Each input port has a small elastic buffer that holds arriving flits. Each output port has its own arbiter. The arbiter picks one requesting input and keeps it for a whole packet. A multi-slot elastic buffer on each output decouples the switch from the downstream channel. Every port uses a valid/ready handshake, and a transfer happens on a rising clock edge where both signals are high.

Routing is look-ahead. A head flit arrives already naming the output it must take here. While the packet waits for its grant, the router computes, in dimension order (X first, then Y), the output the packet will need at the next router. It writes that code into the head flit on the way out. Arbitration is registered, so a grant decided in one cycle steers the switch in the next. A packet that wins on an idle output therefore crosses one cycle after its head becomes visible at the input.

Top module: `eb_router`

## Requirements
- R1: While reset is asserted and immediately after it, every `out_valid_o` bit is 0 and every `in_ready_o` bit is 1.
- R2: A flit is 66 bits. Bit 65 marks a head flit, bit 64 marks a tail flit, and bits 63:0 are payload. A one-flit packet sets both marks. In a head flit, bits [2:0] hold the output to take at this router, bits [5:3] the destination x and bits [8:6] the destination y. Port codes are 0 local, 1 east (+x), 2 west (-x), 3 north (+y), 4 south (-y). Port n of each bus slice `[n*66 +: 66]` uses code n, and every packet leaves on the output its head names.
- R3: On a head flit leaving output o, bits [2:0] are replaced by the dimension-order route from the neighbour router in direction o (router position MY_X, MY_Y) to the destination. The route is east/west if the x values differ, otherwise north/south if the y values differ, otherwise local. A head leaving the local output carries 0. All other bits and all body flits pass unchanged.
- R4: Once an output has taken a packet's head, it takes flits from no other input until that packet's tail has crossed. The flits of a packet leave contiguously and in order.
- R5: When several inputs contend for an idle output, the winner is the first requester in index order starting one past the previous winner of that output, wrapping from 4 to 0. After reset the search starts at input 0.
- R6: Each input buffer holds two flits. `in_ready_o` drops when it is full, and a flit is accepted only on an edge where valid and ready are both high.
- R7: Each output buffer holds three flits. While `out_ready_i` is low, `out_valid_o` stays high and the output flit stays stable. No flit is lost or duplicated under backpressure.
- R8: A flit crosses the switch only when its input holds it, the input owns the output, and the output buffer has room. Packets between disjoint input/output pairs move concurrently at one flit per cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_flit_i | input | 330 | Five incoming flits, 66 bits each |
| in_valid_i | input | 5 | Incoming flit valid, per port |
| in_ready_o | output | 5 | Input buffer has room, per port |
| out_flit_o | output | 330 | Five outgoing flits, 66 bits each |
| out_valid_o | output | 5 | Outgoing flit valid, per port |
| out_ready_i | input | 5 | Downstream accepts, per port |

## Verification
A grant that slips to another input mid-packet shows up at the output within one flit. The next flit comes from the wrong queue, so the per-source scoreboard flags the first flit out of sequence. A wrong round-robin pointer shows only the next time an output is contended, as a changed source order among single-flit packets. A miscounted buffer occupancy shows up within a few cycles of a stall, either as `in_ready_o` staying high with the buffers full or as a lost or duplicated flit when the stall ends. A bad look-ahead computation corrupts the very first head flit that leaves on the affected output.

// File: rtl/eb_router_pkg.sv
`timescale 1ns/1ps
package eb_router_pkg;
  localparam int NUM_PORTS = 5;
  localparam int PORT_W    = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  // dimension-order: resolve x first, then y
  function automatic port_e xy_route(input int cx, input int cy, input int dx, input int dy);
    if (dx > cx) return PORT_EAST;
    if (dx < cx) return PORT_WEST;
    if (dy > cy) return PORT_NORTH;
    if (dy < cy) return PORT_SOUTH;
    return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/eb_fifo.sv
`timescale 1ns/1ps
module eb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o))); // R7
endmodule

// File: rtl/eb_rr_lock.sv
`timescale 1ns/1ps
module eb_rr_lock #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          release_i,
  output logic          lock_o,
  output logic [IW-1:0] owner_o
);
  logic [IW-1:0] ptr_q, owner_q, win;
  logic          lock_q, found;
  int            idx;

  always_comb begin
    found = 1'b0;
    win   = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
  end

  // grant registered: decided this cycle, steers the switch next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (lock_q) begin
      if (release_i) begin
        lock_q <= 1'b0;
        ptr_q  <= (owner_q == IW'(N-1)) ? '0 : owner_q + 1'b1;
      end
    end else if (found) begin
      lock_q  <= 1'b1;
      owner_q <= win;
    end
  end

  assign lock_o  = lock_q;
  assign owner_o = owner_q;

  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !release_i) |=> (lock_q && $stable(owner_q))); // R4
  AST_RELEASE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> lock_q); // R4
endmodule

// File: rtl/eb_router.sv
`timescale 1ns/1ps
module eb_router
  import eb_router_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int COORD_W   = 3,
  parameter int MY_X      = 3,
  parameter int MY_Y      = 4,
  parameter int IN_DEPTH  = 2,
  parameter int OUT_DEPTH = 3,
  localparam int NP       = NUM_PORTS,
  localparam int FLIT_W   = DATA_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP*FLIT_W-1:0] in_flit_i,
  input  logic [NP-1:0]        in_valid_i,
  output logic [NP-1:0]        in_ready_o,
  output logic [NP*FLIT_W-1:0] out_flit_o,
  output logic [NP-1:0]        out_valid_o,
  input  logic [NP-1:0]        out_ready_i
);
  localparam int IW       = $clog2(NP);
  localparam int HEAD_BIT = FLIT_W - 1;
  localparam int TAIL_BIT = FLIT_W - 2;
  localparam int DX_LSB   = PORT_W;
  localparam int DY_LSB   = PORT_W + COORD_W;

  logic [FLIT_W-1:0] in_data [NP];
  logic              in_vld  [NP];
  logic              in_full [NP];
  logic              in_pop  [NP];
  logic [NP-1:0]     req     [NP];
  logic              lock    [NP];
  logic [IW-1:0]     owner   [NP];
  logic              push    [NP];
  logic [NP-1:0]     owned_by[NP];

  // input stages
  for (genvar i = 0; i < NP; i++) begin : g_in
    eb_fifo #(.W(FLIT_W), .DEPTH(IN_DEPTH)) u_in_eb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[i] & ~in_full[i]),
      .data_i  (in_flit_i[i*FLIT_W +: FLIT_W]),
      .pop_i   (in_pop[i]),
      .data_o  (in_data[i]),
      .valid_o (in_vld[i]),
      .full_o  (in_full[i])
    );
    assign in_ready_o[i] = ~in_full[i];

    AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owned_by[i])); // R4
  end

  // a waiting head requests the output it names
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req[o][i] = in_vld[i] & in_data[i][HEAD_BIT] &
                    (in_data[i][PORT_W-1:0] == PORT_W'(o));
      end
    end
  end

  // per-output arbiter, crossbar leg, look-ahead rewrite, output stage
  for (genvar o = 0; o < NP; o++) begin : g_out
    localparam int NX = (o == 1) ? MY_X + 1 : (o == 2) ? MY_X - 1 : MY_X;
    localparam int NY = (o == 3) ? MY_Y + 1 : (o == 4) ? MY_Y - 1 : MY_Y;

    logic [FLIT_W-1:0] sel, fwd;
    logic              sel_vld, out_full, rel;

    eb_rr_lock #(.N(NP)) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req[o]),
      .release_i (rel),
      .lock_o    (lock[o]),
      .owner_o   (owner[o])
    );

    always_comb begin
      sel     = in_data[owner[o]];
      sel_vld = in_vld[owner[o]];
      fwd     = sel;
      if (sel[HEAD_BIT]) begin
        if (o == 0) fwd[PORT_W-1:0] = PORT_LOCAL;
        else        fwd[PORT_W-1:0] = xy_route(NX, NY,
                                        int'(sel[DX_LSB +: COORD_W]),
                                        int'(sel[DY_LSB +: COORD_W]));
      end
    end

    assign push[o] = lock[o] & sel_vld & ~out_full;
    assign rel     = push[o] & sel[TAIL_BIT];

    eb_fifo #(.W(FLIT_W), .DEPTH(OUT_DEPTH)) u_out_eb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[o]),
      .data_i  (fwd),
      .pop_i   (out_ready_i[o] & out_valid_o[o]),
      .data_o  (out_flit_o[o*FLIT_W +: FLIT_W]),
      .valid_o (out_valid_o[o]),
      .full_o  (out_full)
    );

    AST_HEAD_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push[o] && sel[HEAD_BIT]) |-> (sel[PORT_W-1:0] == PORT_W'(o))); // R2
  end

  // input pops when the output it owns takes a flit
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_pop[i]   = 1'b0;
      owned_by[i] = '0;
    end
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (lock[o] && owner[o] == IW'(i)) begin
          owned_by[i][o] = 1'b1;
          if (push[o]) in_pop[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: tb/tb_eb_router.sv
`timescale 1ns/1ps
module tb_eb_router;
  localparam int NP = 5, DATA_W = 64, FLIT_W = DATA_W + 2;
  localparam int MY_X = 3, MY_Y = 4;
  localparam int HEAD_BIT = FLIT_W - 1, TAIL_BIT = FLIT_W - 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP*FLIT_W-1:0] in_flit_v, out_flit_v;
  logic [NP-1:0] in_valid_v, in_ready_v, out_valid_v, out_ready_v;

  logic [FLIT_W-1:0] drv_flit [NP];
  logic              drv_vld  [NP];
  logic              rdy      [NP];
  logic [FLIT_W-1:0] obs_flit [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_flit_v[i*FLIT_W +: FLIT_W] = drv_flit[i];
      in_valid_v[i]  = drv_vld[i];
      out_ready_v[i] = rdy[i];
      obs_flit[i]    = out_flit_v[i*FLIT_W +: FLIT_W];
    end
  end

  eb_router #(.DATA_W(DATA_W), .MY_X(MY_X), .MY_Y(MY_Y)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_flit_i(in_flit_v), .in_valid_i(in_valid_v), .in_ready_o(in_ready_v),
    .out_flit_o(out_flit_v), .out_valid_o(out_valid_v), .out_ready_i(out_ready_v)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, serial = 1, bp_mode = 0;
  logic [FLIT_W-1:0] exp_q [NP*NP][$];
  int src_log [$];
  int cur_src [NP];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [FLIT_W-1:0] act,
                     input logic [FLIT_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // independent model of the look-ahead code (R3)
  function automatic int tb_next(input int o, input int dx, input int dy);
    int nx, ny;
    nx = MY_X; ny = MY_Y;
    if (o == 0) return 0;
    if (o == 1) nx = MY_X + 1;
    if (o == 2) nx = MY_X - 1;
    if (o == 3) ny = MY_Y + 1;
    if (o == 4) ny = MY_Y - 1;
    if (dx > nx) return 1;
    if (dx < nx) return 2;
    if (dy > ny) return 3;
    if (dy < ny) return 4;
    return 0;
  endfunction

  // driver: builds a packet, queues expected flits, drives the handshake
  task automatic send_pkt(input int i, input int port, input int len, input int dx, input int dy);
    int tag;
    tag = serial;
    serial++;
    for (int k = 0; k < len; k++) begin
      logic [FLIT_W-1:0] f, e;
      bit r;
      f = '0;
      f[DATA_W-1:0] = {$urandom, $urandom};
      f[47:32] = tag[15:0];
      f[55:48] = k[7:0];
      f[HEAD_BIT] = (k == 0);
      f[TAIL_BIT] = (k == len - 1);
      if (k == 0) begin
        f[2:0] = port[2:0];
        f[5:3] = dx[2:0];
        f[8:6] = dy[2:0];
      end
      e = f;
      if (k == 0) e[2:0] = 3'(tb_next(port, dx, dy));
      exp_q[port*NP + i].push_back(e);
      @(negedge clk);
      drv_flit[i] = f;
      drv_vld[i]  = 1'b1;
      forever begin
        r = in_ready_v[i];
        @(posedge clk);
        if (r) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    drv_vld[i] = 1'b0;
  endtask

  task automatic mon_take(input int o, input logic [FLIT_W-1:0] f);
    logic [FLIT_W-1:0] e;
    int found;
    if (cur_src[o] < 0) begin
      found = -1;
      e = '0;
      for (int i = 0; i < NP; i++)
        if (found < 0 && exp_q[o*NP + i].size() > 0 && exp_q[o*NP + i][0] == f) found = i;
      if (found < 0)
        for (int i = 0; i < NP; i++)
          if (exp_q[o*NP + i].size() > 0 && e == '0) e = exp_q[o*NP + i][0];
      chk(found >= 0, $sformatf("R3 head on output %0d matches no expected packet start (R2 routing)", o), f, e);
      if (found >= 0) begin
        void'(exp_q[o*NP + found].pop_front());
        if (o == 0) src_log.push_back(found);
        if (!f[TAIL_BIT]) cur_src[o] = found;
      end
    end else begin
      e = '0;
      if (exp_q[o*NP + cur_src[o]].size() > 0) e = exp_q[o*NP + cur_src[o]].pop_front();
      chk(f == e, $sformatf("R4 body flit on output %0d out of packet order", o), f, e);
      if (f[TAIL_BIT]) cur_src[o] = -1;
    end
  endtask

  // monitor: picks downstream ready, then records the transfer due at the next edge
  initial begin
    forever begin
      @(negedge clk);
      for (int o = 0; o < NP; o++) begin
        case (bp_mode)
          0:       rdy[o] = 1'b1;
          1:       rdy[o] = 1'b0;
          default: rdy[o] = (($urandom % 4) != 0);
        endcase
      end
      #1;
      if (rst_ni)
        for (int o = 0; o < NP; o++)
          if (out_valid_v[o] && rdy[o]) mon_take(o, obs_flit[o]);
    end
  end

  task automatic drain();
    int left;
    left = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      left = 0;
      for (int q = 0; q < NP*NP; q++) left += exp_q[q].size();
      if (left == 0) break;
    end
    repeat (4) @(negedge clk);
    chk(left == 0, "R7 flits never delivered", FLIT_W'(left), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int t0, el;
    logic [FLIT_W-1:0] snap;
    int exp_order [5];
    for (int i = 0; i < NP; i++) begin
      drv_flit[i] = '0;
      drv_vld[i]  = 1'b0;
      rdy[i]      = 1'b1;
      cur_src[i]  = -1;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid_v == '0, "R1 out_valid during reset", FLIT_W'(out_valid_v), '0);
    chk(in_ready_v == '1, "R1 in_ready during reset", FLIT_W'(in_ready_v), FLIT_W'(5'h1f));
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid_v == '0, "R1 out_valid after reset", FLIT_W'(out_valid_v), '0);
    chk(in_ready_v == '1, "R1 in_ready after reset", FLIT_W'(in_ready_v), FLIT_W'(5'h1f));

    // R5: contention on the local output, then a wrapped second round
    fork
      send_pkt(1, 0, 1, MY_X, MY_Y);
      send_pkt(2, 0, 1, MY_X, MY_Y);
      send_pkt(3, 0, 1, MY_X, MY_Y);
    join
    drain();
    fork
      send_pkt(1, 0, 1, MY_X, MY_Y);
      send_pkt(4, 0, 1, MY_X, MY_Y);
    join
    drain();
    exp_order = '{1, 2, 3, 4, 1};
    chk(src_log.size() == 5, "R5 grant count on local output", FLIT_W'(src_log.size()), FLIT_W'(5));
    for (int k = 0; k < 5 && k < src_log.size(); k++)
      chk(src_log[k] == exp_order[k], $sformatf("R5 grant order slot %0d", k),
          FLIT_W'(src_log[k]), FLIT_W'(exp_order[k]));

    // R8: disjoint pairs run concurrently, R3 exercised with varied destinations
    @(negedge clk);
    t0 = cyc;
    fork
      send_pkt(1, 2, 8, 0, 6);
      send_pkt(2, 1, 8, 7, 1);
    join
    el = cyc - t0;
    chk(el <= 13, "R8 disjoint packets not concurrent (cycles)", FLIT_W'(el), FLIT_W'(13));
    drain();

    // R6/R7: stall an output and watch both buffers fill
    bp_mode = 1;
    fork
      send_pkt(3, 4, 8, 5, 0);
    join_none
    repeat (20) @(negedge clk);
    #1;
    chk(in_ready_v[3] == 1'b0, "R6 in_ready with both buffers full", FLIT_W'(in_ready_v[3]), '0);
    chk(out_valid_v[4] == 1'b1, "R7 out_valid held under stall", FLIT_W'(out_valid_v[4]), FLIT_W'(1));
    snap = obs_flit[4];
    repeat (5) @(negedge clk);
    #1;
    chk(obs_flit[4] == snap && out_valid_v[4], "R7 output flit stable under stall", obs_flit[4], snap);
    bp_mode = 0;
    wait fork;
    drain();

    // mixed traffic with random backpressure and packet lengths
    bp_mode = 2;
    for (int i = 0; i < NP; i++) begin
      fork
        automatic int ii = i;
        begin
          for (int p = 0; p < 6; p++)
            send_pkt(ii, int'($urandom % 5), 1 + int'($urandom % 8),
                     int'($urandom % 8), int'($urandom % 8));
        end
      join_none
    end
    wait fork;
    drain();
    bp_mode = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid_v == '0, "R7 spurious output after drain", FLIT_W'(out_valid_v), '0);
    summary();
    $finish;
  end
endmodule